// File: doc/BRIEF.md
# Log-Corrected PWM Channel Bank

This block drives a row of independent pulse-width-modulated outputs, one per LED colour channel. Every channel has its own 8-bit brightness input. The block first passes that value through a fixed exponential-segment curve, so that equal steps of the input look like equal steps of brightness to the eye. It then compares the corrected value with a count that all channels share, and drives the output from the result.

A prescaler divides the system clock into a slow step enable. At 50 MHz with a divide ratio of 2, the count steps at 25 MHz and one 256-step PWM period lasts about 100 kHz. Every channel is a real, non-multiplexed output, so all of them can be high in the same cycle.

A channel takes up a new brightness value only when a PWM period starts. A change in the middle of a period therefore never produces a cut-short or stretched pulse.

Top module: `lumen_pwm_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is low after that edge, and every channel's active duty is cleared to 0.
- R2: The shared count advances by one every `DIV` system clocks and wraps from 255 to 0, so one PWM period is 256*`DIV` clocks long.
- R3: The corrected duty `c` is computed from the brightness `v` (bits [7:5] give the segment `e`, bits [4:0] give the mantissa `m`) as follows: `c = 0` when `v = 0`, `c = 255` when `v = 255`, and otherwise `c = (((32+m) << e) >> 5) - 1`. Examples: 32 gives 1, 64 gives 3, 100 gives 8, 128 gives 15, 160 gives 31, 200 gives 79, 254 gives 247.
- R4: A channel with a corrected duty of 0 never drives its output high.
- R5: A channel with a corrected duty of 255 drives its output high for the whole period.
- R6: For any other corrected duty `c`, the output is high exactly while the count lies in 0..c-1, which is `c`*`DIV` clocks per period, beginning at the start of the period.
- R7: A channel takes a new brightness value only in the clock where the count wraps to 0. A change at any other time does not affect the output until the next period starts.
- R8: Channel `i` uses only bits [8i+7:8i] of `level_i` and drives only `pwm_o[i]`. Channels with different values produce their own duty cycles at the same time, and any number of outputs may be high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| level_i | input | 8*NCH | Brightness per channel; channel i occupies bits [8i+7:8i] |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
The main function is exercised with a table of brightness values. The table is rotated across the channels, so each round applies eight different levels at once. Each output's high time over one full period is then compared with the corrected-duty value. The two ends of the range (0 and 255) separate the constant-output cases from an ordinary compare, and the mid-curve points separate the segment and mantissa arithmetic of the correction. A channel holding a one-step duty serves as a marker for the period start. With it, the bench checks the step rate, and checks that a brightness change made in mid-period (from 0 to 255 and back) takes effect only at the next period boundary.

// File: rtl/lumen_pkg.sv
// Shared constants and the brightness correction curve.
// Assumes 8-bit brightness split into a 3-bit segment and a 5-bit mantissa.
package lumen_pkg;
    localparam int LVL_W = 8;
    localparam int SEG_W = 3;
    localparam int MAN_W = 5;
    localparam int MAG_W = MAN_W + 1 + (1 << SEG_W) - 1;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    // Exponential-segment correction: the input is read as a float, then rescaled.
    function automatic logic [LVL_W-1:0] lum_curve(input logic [LVL_W-1:0] v);
        logic [MAG_W-1:0] mag;
        logic [LVL_W-1:0] res;
        mag = {{(MAG_W-MAN_W-1){1'b0}}, 1'b1, v[MAN_W-1:0]} << v[LVL_W-1:MAN_W];
        if (v == '0)
            res = '0;
        else if (v == LVL_MAX)
            res = LVL_MAX;
        else
            res = mag[MAN_W +: LVL_W] - LVL_W'(1);
        return res;
    endfunction
endpackage

// File: rtl/lumen_tick.sv
// Prescaler: emits a one-clock step enable every DIV system clocks.
// Assumes DIV >= 1; when DIV is 1 the enable stays high.
module lumen_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DCW = $clog2(DIV);
            localparam logic [DCW-1:0] LAST = DCW'(DIV - 1);
            logic [DCW-1:0] dcnt;

            // Count system clocks within one step interval.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dcnt <= '0;
                else if (dcnt == LAST)
                    dcnt <= '0;
                else
                    dcnt <= dcnt + DCW'(1);
            end

            assign tick = (dcnt == LAST);

            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/lumen_phase.sv
// Shared PWM count: steps on each tick and flags the wrap into a new period.
// Assumes tick comes from the prescaler in the same clock domain.
module lumen_phase
    import lumen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [LVL_W-1:0] cnt,
    output logic             wrap
);
    // Advance the period count once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + LVL_W'(1);
    end

    assign wrap = tick && (cnt == LVL_MAX);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R2
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
endmodule

// File: rtl/lumen_chan.sv
// One PWM channel: corrects the brightness, holds it for one period, compares.
// Assumes cnt and wrap come from the shared lumen_phase instance.
module lumen_chan
    import lumen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] cnt,
    input  logic             wrap,
    output logic             pwm
);
    logic [LVL_W-1:0] corr;
    logic [LVL_W-1:0] duty_q;

    // Look up the corrected duty for the incoming brightness.
    always_comb corr = lum_curve(level);

    // Capture the corrected duty only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= '0;
        else if (wrap)
            duty_q <= corr;
    end

    assign pwm = (duty_q == LVL_MAX) || (cnt < duty_q);

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));
    // R4
    dark_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm);
    // R5
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == LVL_MAX) |-> pwm);
endmodule

// File: rtl/lumen_pwm_bank.sv
// Top: NCH independent log-corrected PWM outputs sharing one prescaled count.
// Assumes level_i packs channel i at bits [8i+7:8i]; synchronous active-low reset.
module lumen_pwm_bank
    import lumen_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*LVL_W-1:0] level_i,
    output logic [NCH-1:0]       pwm_o
);
    logic             tick;
    logic             wrap;
    logic [LVL_W-1:0] cnt;

    lumen_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    lumen_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            lumen_chan u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .level (level_i[i*LVL_W +: LVL_W]),
                .cnt   (cnt),
                .wrap  (wrap),
                .pwm   (pwm_o[i])
            );
        end
    endgenerate

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (pwm_o == '0));
endmodule

// File: tb/tb_lumen_pwm_bank.sv
module tb_lumen_pwm_bank;
    localparam int NCH = 16;
    localparam int DIV = 2;
    localparam int PER = 256 * DIV;

    localparam logic [7:0] LVL_TAB [8] = '{8'd0, 8'd255, 8'd32, 8'd64, 8'd100, 8'd160, 8'd200, 8'd254};
    localparam int         EXP_TAB [8] = '{0, 255, 1, 3, 8, 31, 79, 247};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH*8-1:0] level_i = '0;
    logic [NCH-1:0]   pwm_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int hcnt [NCH];

    always #5 clk = ~clk;

    lumen_pwm_bank #(.NCH(NCH), .DIV(DIV)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_i),
        .pwm_o   (pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_all(input logic [7:0] v);
        for (int i = 0; i < NCH; i++) level_i[i*8 +: 8] = v;
    endtask

    task automatic count_window();
        for (int i = 0; i < NCH; i++) hcnt[i] = 0;
        repeat (PER) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) if (pwm_o[i]) hcnt[i]++;
        end
    endtask

    task automatic wait_rise0();
        for (int n = 0; n < 2 * PER; n++) begin
            @(negedge clk);
            if (pwm_o[0]) break;
        end
    endtask

    initial begin
        int bad;
        int run;
        int gap;
        // R1: outputs low while in reset
        set_all(8'd255);
        repeat (4) @(negedge clk);
        check("R1 outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 duty cleared after reset", int'(pwm_o), 0);

        // Table walk: rotated levels across channels (R3, R4, R5, R6, R8)
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < NCH; i++) level_i[i*8 +: 8] = LVL_TAB[(i + k) % 8];
            repeat (2 * PER) @(negedge clk);
            count_window();
            for (int i = 0; i < NCH; i++) begin
                int e;
                e = EXP_TAB[(i + k) % 8];
                if (e == 0)
                    check("R4 R8 dark channel high count", hcnt[i], 0);
                else if (e == 255)
                    check("R5 R8 full channel high count", hcnt[i], PER);
                else
                    check("R3 R6 R8 corrected high count", hcnt[i], e * DIV);
            end
        end

        // R8: all outputs high together
        set_all(8'd255);
        repeat (2 * PER) @(negedge clk);
        check("R8 all outputs high together", int'(pwm_o), (1 << NCH) - 1);

        // R2: marker channel at corrected duty 1; run length and period
        set_all(8'd0);
        level_i[7:0] = 8'd32;
        repeat (2 * PER) @(negedge clk);
        wait_rise0();
        run = 0;
        gap = 0;
        while (pwm_o[0] && run < PER) begin run++; gap++; @(negedge clk); end
        while (!pwm_o[0] && gap < 2 * PER) begin gap++; @(negedge clk); end
        check("R2 step length in clocks", run, DIV);
        check("R2 period length in clocks", gap, PER);

        // R7: raise ch1 mid-period; no effect until next start
        wait_rise0();
        repeat (100) @(negedge clk);
        level_i[15:8] = 8'd255;
        bad = 0;
        for (int n = 0; n < 2 * PER; n++) begin
            @(negedge clk);
            if (pwm_o[0]) break;
            if (pwm_o[1]) bad++;
        end
        check("R7 no early rise after mid-period change", bad, 0);
        check("R7 new duty at period start", int'(pwm_o[1]), 1);

        // R7: drop ch1 mid-period; stays high until next start
        repeat (100) @(negedge clk);
        level_i[15:8] = 8'd0;
        bad = 0;
        for (int n = 0; n < 2 * PER; n++) begin
            @(negedge clk);
            if (pwm_o[0]) break;
            if (!pwm_o[1]) bad++;
        end
        check("R7 no early fall after mid-period change", bad, 0);
        check("R7 zero duty at period start", int'(pwm_o[1]), 0);

        // R1: reset in mid-run forces outputs low
        set_all(8'd255);
        repeat (2 * PER) @(negedge clk);
        check("R1 pre-reset all high", int'(pwm_o), (1 << NCH) - 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 outputs low after reset edge", int'(pwm_o), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 R7 duty stays cleared until first wrap", int'(pwm_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule